// File: doc/BRIEF.md
# Power-Gating Domain Sequencer

This block is an always-on controller that takes one switchable logic domain from running to unpowered and back. When the domain has been idle long enough and a power-down is requested, the block clamps the domain outputs, strobes the retention registers to save their state, and opens the footer switch chain. It then waits for the chain to confirm. On a wake request it closes the switches and waits for confirmation. After a programmable settle time it strobes a restore, releases the clamp and reports the domain ready.

Each sequence always runs to its end. A wake request that arrives while the domain is still being shut down is remembered. It is acted on as soon as the domain reaches the off state. The minimum idle time before gating is a parameter in clock cycles. At a 125 MHz clock, the default of 125000 cycles is about 1 ms.

Top module: `pg_seq`

## Requirements
- R1: After reset, `sleep_o`, `iso_o`, `save_o` and `restore_o` are 0, `state_o` is 0 and `ready_o` is 1.
- R2: A power-down starts only after `idle_i` has been high on IDLE_CYCLES consecutive clock edges while `down_req_i` is high. With both inputs raised together from an idle count of zero, `state_o` first leaves 0 after edge IDLE_CYCLES+1.
- R3: Power-down order: `iso_o` rises first. `save_o` is high for exactly one cycle, starting one cycle after `iso_o` rises. `sleep_o` rises in the cycle right after the save pulse.
- R4: With `sleep_o` high, the block stays in ENTERING until it samples `sw_ack_i` high. It then enters OFF on the next edge.
- R5: In OFF, a sampled wake request makes `sleep_o` fall on the next edge, and `state_o` becomes WAKING.
- R6: After `sw_ack_i` is sampled low in WAKING, `restore_o` pulses for exactly one cycle, `settle_i` cycles later. A `settle_i` of 0 gives the pulse on the very next cycle.
- R7: `iso_o` falls in the cycle after the restore pulse. At that point `ready_o` rises and `state_o` returns to 0.
- R8: A wake request seen during ENTERING is held, even if it arrives in the same cycle as the acknowledge. OFF is then left one cycle after it is entered.
- R9: A wake request in ACTIVE has no effect. `down_req_i` without a qualified idle period has no effect.
- R10: `state_o` encodes 0 = ACTIVE, 1 = ENTERING, 2 = OFF, 3 = WAKING. `ready_o` is high exactly when `state_o` is 0.
- R11: `sleep_o` is never high while `iso_o` is low. `save_o` and `restore_o` are only high with `iso_o` high and `sleep_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Domain reports it is idle |
| down_req_i | input | 1 | Request to gate the domain |
| wake_req_i | input | 1 | Request to power the domain back up |
| sw_ack_i | input | 1 | Switch chain acknowledge: 1 = switches off, 0 = switches on |
| settle_i | input | SETTLE_W | Settle cycles between wake acknowledge and restore |
| sleep_o | output | 1 | Footer switch control, 1 = switch off |
| iso_o | output | 1 | Output clamp enable, clamps to 0 when high |
| save_o | output | 1 | Retention save strobe |
| restore_o | output | 1 | Retention restore strobe |
| state_o | output | 2 | Sequencer status code |
| ready_o | output | 1 | Domain powered and released |

## Verification
Two events can fall into the same cycle: the switch acknowledge that ends a power-down, and the arrival of a wake request. The bench raises the wake request on exactly the cycle in which the acknowledge first appears, so that both are sampled on the same edge. The check is that OFF is entered and then left one cycle later. Other runs place the wake early in ENTERING, or a random number of cycles into OFF. Settle values and acknowledge lags are randomized, and every edge of the sequence is timed against the expected cycle.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;
  typedef enum logic [2:0] {
    PH_ACT, PH_ISO, PH_SAVE, PH_SLP, PH_OFF, PH_WON, PH_SETTLE, PH_RESTORE
  } phase_e;

  localparam logic [1:0] ST_ACTIVE   = 2'd0;
  localparam logic [1:0] ST_ENTERING = 2'd1;
  localparam logic [1:0] ST_OFF      = 2'd2;
  localparam logic [1:0] ST_WAKING   = 2'd3;

  function automatic logic [1:0] phase_status(phase_e p);
    case (p)
      PH_ACT:                    return ST_ACTIVE;
      PH_ISO, PH_SAVE, PH_SLP:   return ST_ENTERING;
      PH_OFF:                    return ST_OFF;
      default:                   return ST_WAKING;
    endcase
  endfunction
endpackage

// File: rtl/pg_idle_qual.sv
module pg_idle_qual #(
  parameter int unsigned IDLE_CYCLES = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  output logic ok_o
);
  localparam int unsigned CW = (IDLE_CYCLES < 1) ? 1 : $clog2(IDLE_CYCLES + 1);

  generate
    if (IDLE_CYCLES == 0) begin : g_none
      assign ok_o = 1'b1;
    end else begin : g_cnt
      localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);
      logic [CW-1:0] cnt_q;

      // consecutive idle edges, saturating at the limit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (!idle_i)     cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end

      assign ok_o = (cnt_q == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/pg_settle_cnt.sv
module pg_settle_cnt #(
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                dec_i,
  input  logic [SETTLE_W-1:0] val_i,
  output logic                zero_o,
  output logic                done_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (val_i == '0);
  assign done_o = (cnt_q == SETTLE_W'(1));
endmodule

// File: rtl/pg_seq_fsm.sv
module pg_seq_fsm
  import pg_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       down_req_i,
  input  logic       wake_req_i,
  input  logic       idle_ok_i,
  input  logic       sw_ack_i,
  input  logic       settle_zero_i,
  input  logic       settle_done_i,
  output logic       settle_load_o,
  output logic       settle_dec_o,
  output logic       sleep_o,
  output logic       iso_o,
  output logic       save_o,
  output logic       restore_o,
  output logic [1:0] state_o,
  output logic       ready_o
);
  phase_e phase_q, phase_d;
  logic   pend_q;
  logic   entering;

  assign entering = (phase_q == PH_ISO) || (phase_q == PH_SAVE) || (phase_q == PH_SLP);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_ACT:     if (down_req_i && idle_ok_i) phase_d = PH_ISO;
      PH_ISO:     phase_d = PH_SAVE;
      PH_SAVE:    phase_d = PH_SLP;
      PH_SLP:     if (sw_ack_i) phase_d = PH_OFF;
      PH_OFF:     if (wake_req_i || pend_q) phase_d = PH_WON;
      PH_WON:     if (!sw_ack_i) phase_d = settle_zero_i ? PH_RESTORE : PH_SETTLE;
      PH_SETTLE:  if (settle_done_i) phase_d = PH_RESTORE;
      PH_RESTORE: phase_d = PH_ACT;
      default:    phase_d = PH_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACT;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      // early wake is remembered until OFF is left
      if (phase_q == PH_OFF)          pend_q <= 1'b0;
      else if (entering && wake_req_i) pend_q <= 1'b1;
    end
  end

  assign settle_load_o = (phase_q == PH_WON) && !sw_ack_i;
  assign settle_dec_o  = (phase_q == PH_SETTLE);
  assign iso_o         = (phase_q != PH_ACT);
  assign sleep_o       = (phase_q == PH_SLP) || (phase_q == PH_OFF);
  assign save_o        = (phase_q == PH_SAVE);
  assign restore_o     = (phase_q == PH_RESTORE);
  assign state_o       = phase_status(phase_q);
  assign ready_o       = (phase_q == PH_ACT);
endmodule

// File: rtl/pg_seq.sv
module pg_seq #(
  parameter int unsigned IDLE_CYCLES = 125000,
  parameter int unsigned SETTLE_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                idle_i,
  input  logic                down_req_i,
  input  logic                wake_req_i,
  input  logic                sw_ack_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                sleep_o,
  output logic                iso_o,
  output logic                save_o,
  output logic                restore_o,
  output logic [1:0]          state_o,
  output logic                ready_o
);
  logic idle_ok, s_zero, s_done, s_load, s_dec;

  pg_idle_qual #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idle_i(idle_i),
    .ok_o  (idle_ok)
  );

  pg_settle_cnt #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(s_load),
    .dec_i (s_dec),
    .val_i (settle_i),
    .zero_o(s_zero),
    .done_o(s_done)
  );

  pg_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .down_req_i   (down_req_i),
    .wake_req_i   (wake_req_i),
    .idle_ok_i    (idle_ok),
    .sw_ack_i     (sw_ack_i),
    .settle_zero_i(s_zero),
    .settle_done_i(s_done),
    .settle_load_o(s_load),
    .settle_dec_o (s_dec),
    .sleep_o      (sleep_o),
    .iso_o        (iso_o),
    .save_o       (save_o),
    .restore_o    (restore_o),
    .state_o      (state_o),
    .ready_o      (ready_o)
  );
endmodule

// File: rtl/pg_seq_chk.sv
module pg_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_ack_i,
  input logic       sleep_o,
  input logic       iso_o,
  input logic       save_o,
  input logic       restore_o,
  input logic [1:0] state_o,
  input logic       ready_o
);
  a_r11_sleep_needs_iso: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> iso_o);

  a_r3_save_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> !save_o);

  a_r3_sleep_after_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> sleep_o);

  a_r11_save_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |-> (iso_o && !sleep_o));

  a_r4_off_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) == 2'd1) |-> $past(sw_ack_i));

  a_r5_wake_from_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> ($past(state_o) == 2'd2 && state_o == 2'd3));

  a_r6_restore_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> !restore_o);

  a_r11_restore_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (iso_o && !sleep_o && !sw_ack_i));

  a_r7_release_after_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> (!iso_o && ready_o));

  a_r10_ready_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == (state_o == 2'd0));
endmodule

bind pg_seq pg_seq_chk u_chk (.*);

// File: tb/sim_pg_seq.sv
module sim_pg_seq;
  localparam int IDLE = 16;
  localparam int SW   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idle = 1'b0, down = 1'b0, wake_mon = 1'b0, wake_dir = 1'b0, ack = 1'b0;
  logic [SW-1:0] settle = '0;
  logic sleep_o, iso_o, save_o, restore_o, ready_o;
  logic [1:0] state_o;

  int checks = 0, fails = 0;

  always #4ns clk = ~clk;

  pg_seq #(.IDLE_CYCLES(IDLE), .SETTLE_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .down_req_i(down),
    .wake_req_i(wake_mon | wake_dir), .sw_ack_i(ack), .settle_i(settle),
    .sleep_o(sleep_o), .iso_o(iso_o), .save_o(save_o), .restore_o(restore_o),
    .state_o(state_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // switch chain model: ack follows sleep after ack_lag edges
  int ack_lag = 1, lag_cnt = 0;
  always @(posedge clk) begin
    if (ack != sleep_o) begin
      if (lag_cnt >= ack_lag - 1) begin ack <= sleep_o; lag_cnt <= 0; end
      else lag_cnt <= lag_cnt + 1;
    end else lag_cnt <= 0;
  end

  // event monitor, samples 2 ns after each edge
  int cyc = 0, t_iso_on, t_iso_off, t_save, t_rest, t_slp_on, t_slp_off;
  int t_ack_on, t_ack_off, t_off, t_wake, n_save, n_rest, wcnt = -1;
  int mode = 3, wdelay = 0, st_at_wake;
  logic p_iso = 0, p_slp = 0, p_ack = 0;
  logic [1:0] p_st = 0;

  always begin
    @(posedge clk); #2ns;
    cyc++;
    if (rst_n) begin
      if (wake_mon) wake_mon = 1'b0;
      if (iso_o && !p_iso) t_iso_on = cyc;
      if (!iso_o && p_iso) t_iso_off = cyc;
      if (save_o) begin n_save++; t_save = cyc; end
      if (restore_o) begin n_rest++; t_rest = cyc; end
      if (sleep_o && !p_slp) t_slp_on = cyc;
      if (!sleep_o && p_slp) begin t_slp_off = cyc; st_at_wake = state_o; end
      if (ack && !p_ack) t_ack_on = cyc;
      if (!ack && p_ack) t_ack_off = cyc;
      if (state_o == 2'd2 && p_st != 2'd2) begin t_off = cyc; wcnt = wdelay; end
      if (mode == 1 && state_o == 2'd1 && p_st == 2'd0) begin wake_mon = 1'b1; t_wake = cyc; end
      if (mode == 2 && ack && !p_ack) begin wake_mon = 1'b1; t_wake = cyc; end
      if (mode == 0 && state_o == 2'd2) begin
        if (wcnt == 0) begin wake_mon = 1'b1; t_wake = cyc; wcnt = -1; end
        else if (wcnt > 0) wcnt--;
      end
      // R11 per-cycle ordering
      chk(!(sleep_o && !iso_o), "R11 sleep without iso", int'(sleep_o), 0);
      chk(!((save_o || restore_o) && (!iso_o || sleep_o)), "R11 strobe ctx", int'(iso_o), 1);
    end
    p_iso = iso_o; p_slp = sleep_o; p_ack = ack; p_st = state_o;
  end

  function automatic int exp_restore(int ack_off, int s);
    return ack_off + 1 + s;
  endfunction

  function automatic int exp_wake_fall(int md, int off, int wk);
    return (md == 0) ? wk + 1 : off + 1;
  endfunction

  task automatic run_seq(input int s, input int lag, input int md, input int wd);
    int n = 0;
    @(negedge clk);
    settle = SW'(s); ack_lag = lag; wdelay = wd; mode = md;
    n_save = 0; n_rest = 0;
    idle = 1'b1; down = 1'b1;
    while (state_o == 2'd0) begin
      @(negedge clk); n++;
      if (n > 200) break;
    end
    chk(n == IDLE + 1, "R2 idle qualify edge", n, IDLE + 1);
    chk(state_o == 2'd1, "R10 entering code", int'(state_o), 1);
    idle = 1'b0; down = 1'b0;
    n = 0;
    while (!ready_o && n < 300) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    mode = 3;
    chk(t_save == t_iso_on + 1, "R3 save after iso", t_save, t_iso_on + 1);
    chk(n_save == 1, "R3 save width", n_save, 1);
    chk(t_slp_on == t_save + 1, "R3 sleep after save", t_slp_on, t_save + 1);
    chk(t_off == t_ack_on + 1, "R4 off after ack", t_off, t_ack_on + 1);
    if (md == 0)
      chk(t_slp_off == exp_wake_fall(md, t_off, t_wake), "R5 wake fall",
          t_slp_off, exp_wake_fall(md, t_off, t_wake));
    else
      chk(t_slp_off == exp_wake_fall(md, t_off, t_wake), "R8 held wake",
          t_slp_off, exp_wake_fall(md, t_off, t_wake));
    chk(st_at_wake == 3, "R5 waking code", st_at_wake, 3);
    chk(t_rest == exp_restore(t_ack_off, s), "R6 restore time", t_rest, exp_restore(t_ack_off, s));
    chk(n_rest == 1, "R6 restore width", n_rest, 1);
    chk(t_iso_off == t_rest + 1, "R7 release", t_iso_off, t_rest + 1);
    chk(ready_o && state_o == 2'd0, "R7 ready", int'(ready_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4217));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk({sleep_o, iso_o, save_o, restore_o} == 4'b0, "R1 outputs low",
        int'({sleep_o, iso_o, save_o, restore_o}), 0);
    chk(state_o == 2'd0 && ready_o, "R1 state", int'(state_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 request without qualified idle
    down = 1'b1; idle = 1'b0;
    repeat (30) @(negedge clk);
    chk(state_o == 2'd0, "R9 down without idle", int'(state_o), 0);
    idle = 1'b1;
    repeat (IDLE - 1) @(negedge clk);
    idle = 1'b0;
    repeat (5) @(negedge clk);
    chk(state_o == 2'd0 && !iso_o, "R9 short idle", int'(state_o), 0);
    down = 1'b0;

    // R9 wake in ACTIVE
    wake_dir = 1'b1;
    repeat (3) @(negedge clk);
    wake_dir = 1'b0;
    repeat (3) @(negedge clk);
    chk(state_o == 2'd0 && !sleep_o && !iso_o, "R9 wake in active", int'(state_o), 0);

    // directed corners: settle 0, wake on ack cycle, early wake, late wake
    run_seq(0, 1, 0, 0);
    run_seq(0, 3, 2, 0);
    run_seq(5, 2, 1, 0);
    run_seq(15, 4, 0, 6);
    run_seq(1, 1, 2, 0);

    for (int i = 0; i < 10; i++)
      run_seq(int'($urandom_range(0, 9)), int'($urandom_range(1, 6)),
              int'($urandom_range(0, 2)), int'($urandom_range(0, 4)));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule